// File: doc/BRIEF.md
# Text-Mode Raster Generator for a Monochrome Panel

This block drives a 480x320 monochrome panel that takes four pixels on every clock. It runs its own line and frame counters and makes the horizontal and vertical sync pulses. From the beam position it looks up a character code in an on-chip character store, then fetches one row of that character's 8x8 glyph from a font table. It sends the glyph row to the panel as two 4-pixel nibbles on two consecutive clocks.

A host fills the character store through a one-cycle write port: an address, a byte and a strobe. Each cell is 8 pixels wide and 8 lines tall, so the default panel holds 60 columns by 40 rows. The font is a small function computed in logic, so the design needs no memory contents. The character lookup, the font lookup and the output register each add one clock. The sync pulses and the data-enable flag go through the same three stages, so they stay lined up with the pixels.

Top module: `lcdtext_gen`

## Requirements
- R1: While reset is held, `px`, `de`, `hsync` and `vsync` are all 0. They stay 0 for the first three clocks after reset is released.
- R2: The internal column counter `h` counts 0 to `H_TOTAL`-1 in clocks and then wraps. `hsync` is high when `h` is in [`H_SYNC_AT`, `H_SYNC_AT`+`H_SYNC_W`). Every output shows the beam position from exactly three clocks earlier.
- R3: The line counter `v` steps by one only when `h` wraps, and it wraps after `V_TOTAL`-1. `vsync` is high when `v` is in [`V_SYNC_AT`, `V_SYNC_AT`+`V_SYNC_W`).
- R4: `de` is high exactly when `h` < `H_ACT_PIX`/4 and `v` < `V_ACT`.
- R5: One 8-pixel cell takes two clocks. When `h` is even, `px` carries glyph-row bits 7..4; when `h` is odd, it carries bits 3..0. `px[3]` is the leftmost pixel and glyph bit 7 is the leftmost pixel of the cell.
- R6: The character shown at (`h`,`v`) is read from store address (`v`/8)*COLS + `h`/2, where COLS = `H_ACT_PIX`/8. The glyph row used is `v` mod 8.
- R7: Glyph row r of code c is c rotated left by r bits (8-bit rotate). The space code 0x20 gives all-zero rows.
- R8: `px` is 0 whenever `de` is 0.
- R9: On a rising clock edge with `wr_en` high, `wr_data` is stored at `wr_addr`, and this works during reset too. The new character shows on every later read of that cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-group clock (one clock per 4 pixels) |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Character store write strobe |
| wr_addr | input | ADDR_W | Character cell index, row-major |
| wr_data | input | 8 | Character code to store |
| px | output | 4 | Four pixels, bit 3 leftmost |
| de | output | 1 | Visible-window flag aligned with `px` |
| hsync | output | 1 | Horizontal sync, active high |
| vsync | output | 1 | Vertical sync, active high |

## Verification
The bench builds a shrunken panel: 64x24 visible pixels (8 columns by 3 rows of cells), a 24-clock line and a 28-line frame. With these values one whole frame is 672 clocks. That lets the bench compare every output of several complete frames against its own position model, including both sync windows and the wrap from the last line to the first. The small store of 24 cells can be filled with distinct codes, so an error in the row-times-columns address sum shows up as a wrong glyph. A marker code in the last cell tests the nibble order at the bottom-right corner of the visible window.

// File: rtl/lcdtext_pkg.sv
`timescale 1ns/1ps
package lcdtext_pkg;

  // Sideband that travels with a pixel group through the pipeline
  typedef struct packed {
    logic act;   // inside visible window
    logic hs;    // horizontal sync
    logic vs;    // vertical sync
    logic half;  // 0: left nibble of the cell, 1: right nibble
  } sync_t;

  typedef struct packed {
    sync_t      sy;
    logic [2:0] row;  // glyph row within the cell
  } beam_t;

  // Font: rotate the code left by the row number; space is blank
  function automatic logic [7:0] glyph_row(input logic [7:0] code,
                                           input logic [2:0] row);
    logic [15:0] dbl;
    dbl = {code, code} << row;
    if (code == 8'h20) return 8'h00;
    return dbl[15:8];
  endfunction

  // Pick the nibble shown on this clock of the 8-pixel cell
  function automatic logic [3:0] pick_nibble(input logic [7:0] bits,
                                             input logic right);
    return right ? bits[3:0] : bits[7:4];
  endfunction

endpackage

// File: rtl/lcdtext_timing.sv
`timescale 1ns/1ps
module lcdtext_timing #(
  parameter int H_TOTAL   = 130,
  parameter int H_ACT     = 120,
  parameter int H_SYNC_AT = 124,
  parameter int H_SYNC_W  = 2,
  parameter int V_TOTAL   = 330,
  parameter int V_ACT     = 320,
  parameter int V_SYNC_AT = 322,
  parameter int V_SYNC_W  = 2,
  parameter int HW        = $clog2(H_TOTAL),
  parameter int VW        = $clog2(V_TOTAL)
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [HW-1:0] hc,
  output logic [VW-1:0] vc,
  output logic          line_end,
  output logic          window,
  output logic          hs_raw,
  output logic          vs_raw
);

  logic frame_end;

  assign line_end  = (hc == HW'(H_TOTAL - 1));
  assign frame_end = line_end && (vc == VW'(V_TOTAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hc <= '0;
      vc <= '0;
    end else if (line_end) begin
      hc <= '0;
      vc <= frame_end ? '0 : vc + 1'b1;
    end else begin
      hc <= hc + 1'b1;
    end
  end

  assign window = (hc < HW'(H_ACT)) && (vc < VW'(V_ACT));
  assign hs_raw = (hc >= HW'(H_SYNC_AT)) && (hc < HW'(H_SYNC_AT + H_SYNC_W));
  assign vs_raw = (vc >= VW'(V_SYNC_AT)) && (vc < VW'(V_SYNC_AT + V_SYNC_W));

endmodule

// File: rtl/lcdtext_char_ram.sv
`timescale 1ns/1ps
module lcdtext_char_ram #(
  parameter int DEPTH = 2400,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we && (32'(waddr) < DEPTH)) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/lcdtext_font_rom.sv
`timescale 1ns/1ps
module lcdtext_font_rom
  import lcdtext_pkg::*;
(
  input  logic       clk,
  input  logic [7:0] code,
  input  logic [2:0] row,
  output logic [7:0] bits
);

  always_ff @(posedge clk) bits <= glyph_row(code, row);

endmodule

// File: rtl/lcdtext_gen.sv
`timescale 1ns/1ps
module lcdtext_gen
  import lcdtext_pkg::*;
#(
  parameter int H_ACT_PIX = 480,
  parameter int V_ACT     = 320,
  parameter int H_TOTAL   = 130,
  parameter int H_SYNC_AT = 124,
  parameter int H_SYNC_W  = 2,
  parameter int V_TOTAL   = 330,
  parameter int V_SYNC_AT = 322,
  parameter int V_SYNC_W  = 2,
  parameter int ADDR_W    = $clog2((H_ACT_PIX / 8) * (V_ACT / 8))
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [7:0]        wr_data,
  output logic [3:0]        px,
  output logic              de,
  output logic              hsync,
  output logic              vsync
);

  localparam int PIX_PER_CLK = 4;
  localparam int CELL_W      = 8;
  localparam int H_ACT       = H_ACT_PIX / PIX_PER_CLK;
  localparam int COLS        = H_ACT_PIX / CELL_W;
  localparam int ROWS        = V_ACT / 8;
  localparam int DEPTH       = COLS * ROWS;
  localparam int HW          = $clog2(H_TOTAL);
  localparam int VW          = $clog2(V_TOTAL);

  // Beam events, named for the checker
  logic [HW-1:0]     hc;
  logic [VW-1:0]     vc;
  logic              line_end;
  logic              window;
  logic              hs_raw;
  logic              vs_raw;
  logic [ADDR_W-1:0] rd_addr;
  logic [7:0]        cell_code;
  logic [7:0]        glyph_bits;
  beam_t             s1;
  sync_t             s2;

  lcdtext_timing #(
    .H_TOTAL(H_TOTAL), .H_ACT(H_ACT), .H_SYNC_AT(H_SYNC_AT), .H_SYNC_W(H_SYNC_W),
    .V_TOTAL(V_TOTAL), .V_ACT(V_ACT), .V_SYNC_AT(V_SYNC_AT), .V_SYNC_W(V_SYNC_W),
    .HW(HW), .VW(VW)
  ) u_tim (
    .clk(clk), .rst_n(rst_n), .hc(hc), .vc(vc), .line_end(line_end),
    .window(window), .hs_raw(hs_raw), .vs_raw(vs_raw)
  );

  // Cell index: two clocks per cell across, eight lines per cell down
  assign rd_addr = window ? ADDR_W'(32'(vc >> 3) * COLS + 32'(hc >> 1)) : '0;

  lcdtext_char_ram #(.DEPTH(DEPTH), .AW(ADDR_W)) u_ram (
    .clk(clk), .we(wr_en), .waddr(wr_addr), .wdata(wr_data),
    .raddr(rd_addr), .rdata(cell_code)
  );

  lcdtext_font_rom u_font (
    .clk(clk), .code(cell_code), .row(s1.row), .bits(glyph_bits)
  );

  // Sideband follows the two lookups, then the output register
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1    <= '0;
      s2    <= '0;
      px    <= '0;
      de    <= 1'b0;
      hsync <= 1'b0;
      vsync <= 1'b0;
    end else begin
      s1.sy.act  <= window;
      s1.sy.hs   <= hs_raw;
      s1.sy.vs   <= vs_raw;
      s1.sy.half <= hc[0];
      s1.row     <= vc[2:0];
      s2         <= s1.sy;
      px         <= s2.act ? pick_nibble(glyph_bits, s2.half) : 4'd0;
      de         <= s2.act;
      hsync      <= s2.hs;
      vsync      <= s2.vs;
    end
  end

endmodule

// File: rtl/lcdtext_chk.sv
`timescale 1ns/1ps
module lcdtext_chk #(
  parameter int HW = 8,
  parameter int VW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic [HW-1:0] hc,
  input logic [VW-1:0] vc,
  input logic          line_end,
  input logic          window,
  input logic          hs_raw,
  input logic          vs_raw,
  input logic [3:0]    px,
  input logic          de,
  input logic          hsync,
  input logic          vsync
);

  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R2
  hc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    line_end |=> hc == '0);
  // R2
  hc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> hc == HW'($past(hc) + 1'b1));
  // R3
  vc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !line_end |=> $stable(vc));
  // R8
  px_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !de |-> px == 4'd0);
  // R4
  de_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> de == $past(window, 3));
  // R2
  hs_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> hsync == $past(hs_raw, 3));
  // R3
  vs_lag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd3) |-> vsync == $past(vs_raw, 3));

endmodule

bind lcdtext_gen lcdtext_chk #(.HW(HW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hc(hc), .vc(vc), .line_end(line_end),
  .window(window), .hs_raw(hs_raw), .vs_raw(vs_raw),
  .px(px), .de(de), .hsync(hsync), .vsync(vsync)
);

// File: tb/sim_lcdtext_gen.sv
`timescale 1ns/1ps
module sim_lcdtext_gen;

  localparam int HPIX  = 64;
  localparam int VACT  = 24;
  localparam int HT    = 24;
  localparam int HSA   = 18;
  localparam int HSW   = 3;
  localparam int VT    = 28;
  localparam int VSA   = 25;
  localparam int VSW   = 2;
  localparam int HA    = HPIX / 4;
  localparam int COLS  = HPIX / 8;
  localparam int ROWS  = VACT / 8;
  localparam int DEPTH = COLS * ROWS;
  localparam int AW    = $clog2(DEPTH);
  localparam int FRAME = HT * VT;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic [3:0]    px;
  logic          de, hsync, vsync;

  int total = 0;
  int fails = 0;
  int edges = 0;
  logic [7:0] shadow [DEPTH];

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (!rst_n) edges <= 0;
    else        edges <= edges + 1;
  end

  lcdtext_gen #(
    .H_ACT_PIX(HPIX), .V_ACT(VACT), .H_TOTAL(HT), .H_SYNC_AT(HSA), .H_SYNC_W(HSW),
    .V_TOTAL(VT), .V_SYNC_AT(VSA), .V_SYNC_W(VSW)
  ) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .px(px), .de(de), .hsync(hsync), .vsync(vsync)
  );

  function automatic int exp_glyph(int c, int r);
    if (c == 32) return 0;
    return ((c << r) | (c >> (8 - r))) & 255;
  endfunction

  // Expected outputs after n clock edges since reset release
  task automatic model(input int n, output int epx, output int eh, output int ev, output int ede);
    int p, h, v, g;
    epx = 0; eh = 0; ev = 0; ede = 0;
    if (n >= 3) begin
      p   = (n - 3) % FRAME;
      h   = p % HT;
      v   = p / HT;
      ede = (h < HA && v < VACT) ? 1 : 0;
      eh  = (h >= HSA && h < HSA + HSW) ? 1 : 0;
      ev  = (v >= VSA && v < VSA + VSW) ? 1 : 0;
      if (ede == 1) begin
        g   = exp_glyph(int'(shadow[(v / 8) * COLS + h / 2]), v % 8);
        epx = (h % 2 == 0) ? (g >> 4) & 15 : g & 15;
      end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input int addr, input int data);
    @(negedge clk);
    wr_en   = 1'b1;
    wr_addr = AW'(addr);
    wr_data = 8'(data);
    shadow[addr] = 8'(data);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // Compare one full frame of outputs against the model
  task automatic run_frame(input string label);
    int epx, eh, ev, ede;
    int bad_px = 0, bad_h = 0, bad_v = 0, bad_de = 0, leak = 0;
    int apx = 0, xpx = 0, ah = 0, xh = 0, av = 0, xv = 0, ad = 0, xd = 0;
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      model(edges, epx, eh, ev, ede);
      if (int'(px) != epx) begin if (bad_px == 0) begin apx = int'(px); xpx = epx; end bad_px++; end
      if (int'(hsync) != eh) begin if (bad_h == 0) begin ah = int'(hsync); xh = eh; end bad_h++; end
      if (int'(vsync) != ev) begin if (bad_v == 0) begin av = int'(vsync); xv = ev; end bad_v++; end
      if (int'(de) != ede) begin if (bad_de == 0) begin ad = int'(de); xd = ede; end bad_de++; end
      if (!de && px != 4'd0) leak++;
    end
    check(bad_px == 0, "R5 R6 R7", {label, " pixels"}, apx, xpx);
    check(bad_h == 0, "R2", {label, " hsync"}, ah, xh);
    check(bad_v == 0, "R3", {label, " vsync"}, av, xv);
    check(bad_de == 0, "R4", {label, " de"}, ad, xd);
    check(leak == 0, "R8", {label, " px outside window"}, leak, 0);
  endtask

  // R1 and R9: fill store under reset, then watch the first clocks
  task automatic t_reset();
    for (int a = 0; a < DEPTH; a++) wr(a, (a * 7 + 8'h21) & 255);
    @(negedge clk);
    check(px == 4'd0 && !de && !hsync && !vsync, "R1", "outputs in reset",
          {de, hsync, vsync, px}, 0);
    rst_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      check(px == 4'd0 && !de && !hsync && !vsync, "R1", "outputs before latency",
            {de, hsync, vsync, px}, 0);
      @(negedge clk);
    end
  endtask

  task automatic t_distinct();
    run_frame("distinct codes R6");
  endtask

  task automatic t_hello();
    int txt [5] = '{8'h48, 8'h65, 8'h6C, 8'h6C, 8'h6F};
    for (int k = 0; k < 5; k++) wr(COLS + 1 + k, txt[k]);
    repeat (FRAME + 4) @(negedge clk);
    run_frame("word on row 1 R9");
  endtask

  task automatic t_blank();
    int lit = 0;
    for (int a = 0; a < DEPTH; a++) wr(a, 8'h20);
    repeat (FRAME + 4) @(negedge clk);
    run_frame("all spaces");
    for (int i = 0; i < FRAME; i++) begin
      @(negedge clk);
      if (px != 4'd0) lit++;
    end
    check(lit == 0, "R7", "space glyph lit pixels", lit, 0);
  endtask

  // R5: last cell, glyph row 0 of 0x81 gives 8 then 1
  task automatic t_corner();
    int p, a0, a1;
    wr(DEPTH - 1, 8'h81);
    repeat (FRAME + 4) @(negedge clk);
    p = (ROWS - 1) * 8 * HT + (COLS - 1) * 2;
    while (((edges - 3) % FRAME) != p) @(negedge clk);
    a0 = int'(px);
    @(negedge clk);
    a1 = int'(px);
    check(a0 == 8, "R5", "left nibble of last cell", a0, 8);
    check(a1 == 1, "R5", "right nibble of last cell", a1, 1);
    run_frame("corner marker");
  endtask

  initial begin
    #2_000_000;
    total++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset();
    t_distinct();
    t_hello();
    t_blank();
    t_corner();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule